// File: doc/BRIEF.md
# Sample FIFO With Byte Readout

This block sits between an analog-to-digital converter and a host that reads one byte at a time. Each 16-bit result the converter delivers is stored in a small FIFO. The host reads a stored result as two successive byte reads, low byte first. The entry leaves the FIFO only when its high byte has been read.

Two sticky error flags are kept. Overflow means a sample was lost because the FIFO was full. Overrun means the converter was asked for a new conversion before the previous result had arrived. An interrupt line tells the host that real data is waiting or that an error flag is set.

A single-cycle strobe on the clear input resets both error flags and withdraws the interrupt. The clear also leaves the FIFO holding exactly one stale word. The host discards that word with two byte reads before it starts new conversions.

Top module: `sample_byte_fifo`

## Requirements
- R1: After reset the FIFO is empty: `level_o`=0, `empty_o`=1, `full_o`=0. `ovf_o`, `ovr_o` and `irq_o` are 0, and `rd_data_o` is 0.
- R2: Samples come out in the order they were written. Each sample takes two byte reads. The first read returns bits [7:0] and the second returns bits [15:8]. `level_o` drops by one only after the second read. A byte read on `rd_i` appears on `rd_data_o` one cycle later and holds until the next read.
- R3: A sample presented while `full_o`=1 is dropped, even if a pop happens in the same cycle. It sets `ovf_o`, which stays at 1 until a clear.
- R4: A conversion is pending from a `conv_req_i` pulse until the next `smp_valid_i`. Overrun is detected when `conv_req_i` arrives while a conversion is pending and `smp_valid_i` is low in that cycle. It sets `ovr_o`, which stays at 1 until a clear.
- R5: A `clr_i` pulse clears `ovf_o` and `ovr_o` in the next cycle and withdraws the interrupt request. It also sets `level_o` to 1, which is the one stale word, and restarts the byte sequence at the low byte.
- R6: After a clear, two byte reads remove the stale word and bring `level_o` to 0. Samples written after that are read back intact.
- R7: `irq_o` is 1 exactly when `ovf_o` or `ovr_o` is set, or the FIFO holds at least one sample that is not the stale word left by a clear.
- R8: A byte read while the FIFO is empty leaves `level_o` and the byte order unchanged. It returns bits [7:0] of the last word whose high byte was read, or 0 if no word has been read since reset.
- R9: When `clr_i` is high, `smp_valid_i` and `rd_i` in the same cycle have no effect on the FIFO contents or on `rd_data_o`.
- R10: `full_o` is 1 when `level_o` equals DEPTH, and `empty_o` is 1 when `level_o` is 0. `level_o` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Converter result strobe |
| smp_data_i | input | 16 | Converter result |
| conv_req_i | input | 1 | Conversion start pulse |
| rd_i | input | 1 | Host byte read strobe |
| rd_data_o | output | 8 | Byte returned by the last read |
| clr_i | input | 1 | Clear strobe for flags and interrupt |
| level_o | output | $clog2(DEPTH+1) | Stored words, stale word included |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| ovf_o | output | 1 | Sticky overflow flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that every strobe is a synchronous single-cycle level sampled at the rising edge. They also assume that `clr_i` may coincide with any other input, and that the content of the stale word is undefined. The stimulus drives all inputs half a cycle away from the edge and deliberately overlaps clear, write and read strobes. It never compares the stale word's bytes or any last word derived from it. The random phase keeps read and write rates near each other so that the FIFO regularly reaches both empty and full.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SMP_W  = 16;

  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
endpackage

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          rd_act_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] level_o,
  output phase_e        phase_o,
  output logic          stale_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] level_q;
  phase_e        phase_q;
  logic          stale_q;

  assign empty_o  = (level_q == '0);
  assign full_o   = (level_q == CW'(DEPTH));
  assign push_o   = push_req_i && !full_o && !clr_i;
  assign rd_act_o = rd_i && !empty_o && !clr_i;
  assign pop_o    = rd_act_o && (phase_q == PH_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      phase_q  <= PH_LO;
      stale_q  <= 1'b0;
    end else if (clr_i) begin
      // leave the word at the read slot in place as the stale entry
      wr_ptr_q <= rd_ptr_q + AW'(1);
      level_q  <= CW'(1);
      phase_q  <= PH_LO;
      stale_q  <= 1'b1;
    end else begin
      if (push_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_o) begin
        rd_ptr_q <= rd_ptr_q + AW'(1);
        stale_q  <= 1'b0;
      end
      if (rd_act_o) phase_q <= (phase_q == PH_LO) ? PH_HI : PH_LO;
      case ({push_o, pop_o})
        2'b10:   level_q <= level_q + CW'(1);
        2'b01:   level_q <= level_q - CW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign level_o  = level_q;
  assign phase_o  = phase_q;
  assign stale_o  = stale_q;
endmodule

// File: rtl/sbf_err.sv
module sbf_err #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic          conv_req_i,
  input  logic          full_i,
  input  logic          clr_i,
  input  logic [CW-1:0] level_i,
  input  logic          stale_i,
  output logic          ovf_o,
  output logic          ovr_o,
  output logic          irq_o
);
  logic pend_q, ovf_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (conv_req_i)       pend_q <= 1'b1;
      else if (smp_valid_i) pend_q <= 1'b0;
      if (clr_i) begin
        ovf_q <= 1'b0;
        ovr_q <= 1'b0;
      end else begin
        if (smp_valid_i && full_i)                 ovf_q <= 1'b1;
        if (conv_req_i && pend_q && !smp_valid_i)  ovr_q <= 1'b1;
      end
    end
  end

  // stale word does not request service
  assign irq_o = (level_i > CW'(stale_i)) || ovf_q || ovr_q;
  assign ovf_o = ovf_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
  import sbf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic              conv_req_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              clr_i,
  output logic [CW-1:0]     level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic             push, pop, rd_act, stale;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;
  phase_e           phase;
  logic [SMP_W-1:0] head;
  logic [SMP_W-1:0] last_q;
  logic [BYTE_W-1:0] rd_byte_q, rd_byte_d;

  sbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_req_i(smp_valid_i), .rd_i(rd_i),
    .clr_i(clr_i), .push_o(push), .pop_o(pop), .rd_act_o(rd_act),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .level_o(level), .phase_o(phase),
    .stale_o(stale), .empty_o(empty_o), .full_o(full_o)
  );

  sbf_store #(.DEPTH(DEPTH), .W(SMP_W)) u_store (
    .clk_i(clk_i), .we_i(push), .waddr_i(wr_ptr), .wdata_i(smp_data_i),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  sbf_err #(.DEPTH(DEPTH)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
    .conv_req_i(conv_req_i), .full_i(full_o), .clr_i(clr_i),
    .level_i(level), .stale_i(stale), .ovf_o(ovf_o), .ovr_o(ovr_o),
    .irq_o(irq_o)
  );

  always_comb begin
    rd_byte_d = rd_byte_q;
    if (rd_act)
      rd_byte_d = (phase == PH_HI) ? head[SMP_W-1 -: BYTE_W] : head[BYTE_W-1:0];
    else if (rd_i && !clr_i)
      rd_byte_d = last_q[BYTE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_byte_q <= '0;
      last_q    <= '0;
    end else begin
      rd_byte_q <= rd_byte_d;
      if (pop) last_q <= head;
    end
  end

  assign rd_data_o = rd_byte_q;
  assign level_o   = level;
endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic          conv_req_i,
  input logic          rd_i,
  input logic          clr_i,
  input logic [CW-1:0] level_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          ovr_o,
  input logic          irq_o
);
  assert_level_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));

  assert_level_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (level_o == $past(level_o) || level_o == $past(level_o) + CW'(1)
                || level_o + CW'(1) == $past(level_o)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && smp_valid_i && !clr_i && !rd_i |=> full_o && ovf_o);

  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o);

  assert_ovr_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !clr_i |=> ovr_o);

  assert_clear_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovf_o && !ovr_o && level_o == CW'(1));

  assert_irq_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || ovr_o) |-> irq_o);

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);

  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !smp_valid_i && !clr_i |=> empty_o);

  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

bind sample_byte_fifo sbf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .conv_req_i(conv_req_i), .rd_i(rd_i), .clr_i(clr_i), .level_o(level_o),
  .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .ovr_o(ovr_o),
  .irq_o(irq_o)
);

// File: tb/sample_byte_fifo_bench.sv
module sample_byte_fifo_bench;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 0, conv_req = 0, rd = 0, clr = 0;
  logic [15:0] smp_data = '0;
  logic [7:0]  rd_data;
  logic [CW-1:0] level;
  logic empty, full, ovf, ovr, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sample_byte_fifo #(.DEPTH(DEPTH)) u_sample_byte_fifo (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .conv_req_i(conv_req), .rd_i(rd), .rd_data_o(rd_data), .clr_i(clr),
    .level_o(level), .empty_o(empty), .full_o(full), .ovf_o(ovf), .ovr_o(ovr),
    .irq_o(irq)
  );

  // model: bit 16 marks a known word
  logic [16:0] mq[$];
  bit m_ph, m_stale, m_ovf, m_ovr, m_pend;
  logic [16:0] m_last;
  logic [8:0]  m_byte;  // bit 8 = known

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq();
    return (mq.size() > int'(m_stale)) || m_ovf || m_ovr;
  endfunction

  task automatic model_step(input bit v, input logic [15:0] d, input bit c,
                            input bit r, input bit k);
    bit was_full = (mq.size() == DEPTH);
    bit was_pend = m_pend;
    if (c) m_pend = 1; else if (v) m_pend = 0;
    if (k) begin
      m_ovf = 0; m_ovr = 0;
      mq.delete(); mq.push_back(17'h0);
      m_ph = 0; m_stale = 1;
    end else begin
      if (v && was_full) m_ovf = 1;
      if (c && was_pend && !v) m_ovr = 1;
      if (r) begin
        if (mq.size() != 0) begin
          m_byte = m_ph ? {mq[0][16], mq[0][15:8]} : {mq[0][16], mq[0][7:0]};
          if (m_ph) begin
            m_last = mq.pop_front();
            m_stale = 0;
          end
          m_ph = ~m_ph;
        end else begin
          m_byte = {m_last[16], m_last[7:0]};
        end
      end
      if (v && !was_full) mq.push_back({1'b1, d});
    end
  endtask

  task automatic compare();
    chk("R10 level", 16'(level), 16'(mq.size()));
    chk("R10 empty", 16'(empty), 16'(mq.size() == 0));
    chk("R10 full", 16'(full), 16'(mq.size() == DEPTH));
    chk("R3 ovf", 16'(ovf), 16'(m_ovf));
    chk("R4 ovr", 16'(ovr), 16'(m_ovr));
    chk("R7 irq", 16'(irq), 16'(exp_irq()));
    if (m_byte[8]) chk("R2/R8/R9 rd_data", 16'(rd_data), 16'(m_byte[7:0]));
  endtask

  task automatic step(input bit v, input logic [15:0] d, input bit c,
                      input bit r, input bit k);
    @(negedge clk);
    smp_valid = v; smp_data = d; conv_req = c; rd = r; clr = k;
    @(posedge clk);
    model_step(v, d, c, r, k);
    #2;
    compare();
  endtask

  task automatic idle(); step(0, 16'h0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    m_last = {1'b1, 16'h0};
    m_byte = 9'h100;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", 16'(level), 16'h0);
    chk("R1 empty", 16'(empty), 16'h1);
    chk("R1 flags", 16'({full, ovf, ovr, irq}), 16'h0);
    chk("R1 rd_data", 16'(rd_data), 16'h0);
    rst_n = 1;
    idle();
    // R8 empty read after reset returns 0
    step(0, 0, 0, 1, 0);
    // R2 ordering and byte split
    step(1, 16'hA1B2, 1, 0, 0);
    step(1, 16'hC3D4, 1, 0, 0);
    step(1, 16'hE5F6, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0);
    // R8 empty read returns low byte of last word, level unchanged
    step(0, 0, 0, 1, 0);
    // R3 fill, overflow, sticky
    for (int i = 0; i < DEPTH; i++) step(1, 16'(16'h1000 + i), 0, 0, 0);
    step(1, 16'hDEAD, 0, 0, 0);
    step(1, 16'hBEEF, 0, 1, 0);
    idle();
    // R4 overrun
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    idle();
    // R5 clear, R6 drain stale word
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(1, 16'h5A69, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    // R9 clear with write and read in same cycle
    step(1, 16'h7777, 0, 0, 0);
    step(1, 16'h3333, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    // random phase
    seed_dummy = $urandom(32'h5EED1234);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom;
      step(r[2:0] < 3'd3, 16'($urandom), r[5:3] == 3'd0, r[8:6] < 3'd4,
           r[14:9] == 6'd0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule